// File: doc/BRIEF.md
# Power Event Interrupt and Wake Router

This block collects power-management events from two status groups and steers them to an active-low system-management interrupt line, an active-low power-management/SCI line and a one-cycle wake request. The legacy group is a status vector that can only reach the SMI line. The ACPI-style group, power-button events plus general-purpose events, always feeds the wake logic. A two-bit routing mode decides whether the ACPI-style group drives the SMI line or the PME line.

Each status bit is set by a one-cycle event pulse, but only while its enable bit is 1. Software clears a status bit by writing 1 to it. Each interrupt line is a level: it stays asserted while any status bit routed to it is set and enabled.

A power-button override locks out wake requests from the ACPI-style group. The next power-button wake pulse releases the lockout, and that pulse raises a wake request of its own.

Top module: `pwr_event_router`

## Requirements
- R1: While reset is applied, and in the cycle after it, every status bit reads 0, `smi_n` and `pme_n` are 1 and `wake_req` is 0.
- R2: An event pulse on bit i sets status bit i at the next clock edge only if enable bit i is 1. With the enable at 0 the pulse is ignored: the status stays 0 and no output changes.
- R3: When `*_clr_we` is 1, status bits whose `*_clr_data` bit is 1 clear at the next edge, and bits written with 0 keep their value. If a set and a clear hit the same bit in the same cycle, the set wins.
- R4: In mode 2'b00 (SMI only), `smi_n` is low exactly while some legacy bit is both set and enabled. ACPI-style status never moves `smi_n` or `pme_n` in this mode.
- R5: In mode 2'b01 (SMI with wake), a set and enabled ACPI-style bit drives `smi_n` low, and `pme_n` stays 1.
- R6: In mode 2'b10 (SCI select), and likewise in 2'b11, a set and enabled ACPI-style bit drives `pme_n` low, and it does not drive `smi_n`.
- R7: Legacy events never raise `wake_req`, in any mode.
- R8: In every mode, an ACPI-style status bit that goes from 0 to 1 makes `wake_req` 1 for exactly the cycle after the setting edge, unless the lockout is active.
- R9: After a `pb_override` pulse, newly set ACPI-style bits still set their status and drive the interrupt lines, but they raise no `wake_req`.
- R10: A `pb_wake` pulse raises `wake_req` in the next cycle and releases the lockout, so later ACPI-style events wake again. If `pb_wake` and `pb_override` arrive together, `pb_wake` wins.
- R11: An interrupt line stays asserted until its status bit is cleared or its enable bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Routing mode: 00 SMI only, 01 SMI with wake, 10/11 SCI select |
| leg_evt | input | LEG_W | Legacy event pulses |
| leg_en | input | LEG_W | Legacy enable bits |
| leg_clr_we | input | 1 | Legacy status clear strobe |
| leg_clr_data | input | LEG_W | Legacy write-one-to-clear data |
| acp_evt | input | ACP_W | ACPI-style event pulses |
| acp_en | input | ACP_W | ACPI-style enable bits |
| acp_clr_we | input | 1 | ACPI-style status clear strobe |
| acp_clr_data | input | ACP_W | ACPI-style write-one-to-clear data |
| pb_override | input | 1 | Power-button override occurred (pulse) |
| pb_wake | input | 1 | Power-button wake press (pulse) |
| leg_sts | output | LEG_W | Legacy status bits |
| acp_sts | output | ACP_W | ACPI-style status bits |
| smi_n | output | 1 | Active-low SMI line |
| pme_n | output | 1 | Active-low PME/SCI line |
| wake_req | output | 1 | One-cycle wake request |

## Verification
Each group is stimulated alone and both together in each of the four mode codes. This shows which line each group reaches and confirms that only the ACPI-style group ever wakes. Events are also sent with the enable off, with a clear in the same cycle, and repeated onto a bit that is already set. These cases tell apart the enable gate, the set-over-clear priority and the rule that only a 0-to-1 change wakes. An override, then an event, then a power-button wake, then another event shows the lockout being entered and released.

// File: rtl/pwr_route_pkg.sv
// Shared routing-mode encodings for the power event router.
package pwr_route_pkg;
    typedef enum logic [1:0] {
        RT_SMI_ONLY = 2'b00,
        RT_SMI_WAKE = 2'b01,
        RT_SCI_SEL  = 2'b10,
        RT_SCI_ALT  = 2'b11
    } route_mode_t;
endpackage

// File: rtl/pwr_evt_bank.sv
// Status bank: a sticky status vector that an enabled event pulse sets
// and a write of 1 clears. A set beats a clear in the same cycle.
// Assumes the event pulses are already synchronous to clk.
module pwr_evt_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] sts,
    output logic         pend,
    output logic         newset
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    // Set and clear masks for this cycle.
    always_comb begin
        set_v  = evt & en;
        clr_v  = clr_we ? clr_data : '0;
        newset = |(set_v & ~sts);
        pend   = |(sts & en);
    end

    // Status register update: clear, then let a set override it.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr_v) | set_v;
    end

    assert_set_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts)) & ~$past(evt & en)) == '0);

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_we) |-> ((sts & $past(clr_data & ~(evt & en))) == '0));
endmodule

// File: rtl/pwr_wake_gate.sv
// Wake gate: turns new ACPI-style status sets and power-button wakes into
// a one-cycle wake request, holding off ACPI-style wakes after an override.
// Assumes pb_override and pb_wake are single-cycle pulses.
module pwr_wake_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic acp_newset,
    input  logic pb_override,
    input  logic pb_wake,
    output logic wake_req
);
    logic lock_q;

    // Lockout flag: a button wake releases it, an override sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)           lock_q <= 1'b0;
        else if (pb_wake)     lock_q <= 1'b0;
        else if (pb_override) lock_q <= 1'b1;
    end

    // Wake pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= pb_wake | (acp_newset & ~lock_q);
    end

    assert_wake_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(pb_wake) || $past(acp_newset)));

    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !$past(pb_wake)) |-> !$past(lock_q));
endmodule

// File: rtl/pwr_out_route.sv
// Output steering: maps the pending levels of both groups onto the
// active-low SMI and PME lines according to the routing mode.
module pwr_out_route
    import pwr_route_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       leg_pend,
    input  logic       acp_pend,
    output logic       smi_n,
    output logic       pme_n
);
    route_mode_t md;

    // Combinational steering of the pending levels.
    always_comb begin
        md    = route_mode_t'(mode);
        smi_n = ~(leg_pend | (acp_pend && md == RT_SMI_WAKE));
        pme_n = ~(acp_pend && (md == RT_SCI_SEL || md == RT_SCI_ALT));
    end
endmodule

// File: rtl/pwr_event_router.sv
// Top: two status banks (legacy and ACPI-style), the output steering and
// the wake gate. Only the ACPI-style bank reaches the wake gate.
module pwr_event_router
    import pwr_route_pkg::*;
#(
    parameter int LEG_W = 4,
    parameter int ACP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [LEG_W-1:0] leg_evt,
    input  logic [LEG_W-1:0] leg_en,
    input  logic             leg_clr_we,
    input  logic [LEG_W-1:0] leg_clr_data,
    input  logic [ACP_W-1:0] acp_evt,
    input  logic [ACP_W-1:0] acp_en,
    input  logic             acp_clr_we,
    input  logic [ACP_W-1:0] acp_clr_data,
    input  logic             pb_override,
    input  logic             pb_wake,
    output logic [LEG_W-1:0] leg_sts,
    output logic [ACP_W-1:0] acp_sts,
    output logic             smi_n,
    output logic             pme_n,
    output logic             wake_req
);
    logic leg_pend, leg_newset;
    logic acp_pend, acp_newset;

    pwr_evt_bank #(.W(LEG_W)) u_leg (
        .clk(clk), .rst_n(rst_n), .evt(leg_evt), .en(leg_en),
        .clr_we(leg_clr_we), .clr_data(leg_clr_data),
        .sts(leg_sts), .pend(leg_pend), .newset(leg_newset)
    );

    pwr_evt_bank #(.W(ACP_W)) u_acp (
        .clk(clk), .rst_n(rst_n), .evt(acp_evt), .en(acp_en),
        .clr_we(acp_clr_we), .clr_data(acp_clr_data),
        .sts(acp_sts), .pend(acp_pend), .newset(acp_newset)
    );

    pwr_out_route u_route (
        .mode(mode), .leg_pend(leg_pend), .acp_pend(acp_pend),
        .smi_n(smi_n), .pme_n(pme_n)
    );

    pwr_wake_gate u_wake (
        .clk(clk), .rst_n(rst_n), .acp_newset(acp_newset),
        .pb_override(pb_override), .pb_wake(pb_wake), .wake_req(wake_req)
    );

    assert_smi_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (route_mode_t'(mode) == RT_SMI_ONLY && !leg_pend) |-> smi_n);

    assert_pme_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> (mode[1] && acp_pend));

    assert_smi_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (route_mode_t'(mode) == RT_SMI_WAKE) |-> pme_n);
endmodule

// File: tb/tb_pwr_event_router.sv
module tb_pwr_event_router;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;
    localparam int AW = 6;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [1:0]    mode = 2'b00;
    logic [LW-1:0] leg_evt = '0, leg_en = '0, leg_clr_data = '0;
    logic          leg_clr_we = 0;
    logic [AW-1:0] acp_evt = '0, acp_en = '0, acp_clr_data = '0;
    logic          acp_clr_we = 0;
    logic          pb_override = 0, pb_wake = 0;
    logic [LW-1:0] leg_sts;
    logic [AW-1:0] acp_sts;
    logic          smi_n, pme_n, wake_req;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_event_router #(.LEG_W(LW), .ACP_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .leg_evt(leg_evt), .leg_en(leg_en), .leg_clr_we(leg_clr_we),
        .leg_clr_data(leg_clr_data),
        .acp_evt(acp_evt), .acp_en(acp_en), .acp_clr_we(acp_clr_we),
        .acp_clr_data(acp_clr_data),
        .pb_override(pb_override), .pb_wake(pb_wake),
        .leg_sts(leg_sts), .acp_sts(acp_sts),
        .smi_n(smi_n), .pme_n(pme_n), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock edge, then return 1 time unit later; pulses drop afterwards.
    task automatic tick();
        @(posedge clk);
        #1;
        leg_evt = '0; acp_evt = '0; leg_clr_we = 0; acp_clr_we = 0;
        pb_override = 0; pb_wake = 0;
    endtask

    task automatic clear_all();
        leg_clr_we = 1; leg_clr_data = '1;
        acp_clr_we = 1; acp_clr_data = '1;
        tick();
        tick();
    endtask

    task automatic t_reset();
        rst_n = 0; leg_en = '1; acp_en = '1; leg_evt = '1; acp_evt = '1;
        @(posedge clk); #1;
        check("R1 leg_sts", leg_sts, 0);
        check("R1 acp_sts", acp_sts, 0);
        check("R1 lines", {smi_n, pme_n, wake_req}, 3'b110);
        leg_evt = '0; acp_evt = '0;
        rst_n = 1;
        tick();
        check("R1 after release", {smi_n, pme_n, wake_req, leg_sts, acp_sts}, {3'b110, 10'd0});
    endtask

    task automatic t_enable_gate();
        mode = 2'b10; leg_en = 4'b0001; acp_en = 6'b000001;
        leg_evt = 4'b0100; acp_evt = 6'b000100;
        tick();
        check("R2 disabled ignored sts", {leg_sts, acp_sts}, 0);
        check("R2 disabled ignored lines", {smi_n, pme_n, wake_req}, 3'b110);
        leg_evt = 4'b0001;
        tick();
        check("R2 enabled sets", leg_sts, 4'b0001);
        check("R2 smi low", smi_n, 0);
        clear_all();
    endtask

    task automatic t_w1c();
        leg_en = '1; leg_evt = 4'b1011;
        tick();
        leg_clr_we = 1; leg_clr_data = 4'b0010;
        tick();
        check("R3 selective clear", leg_sts, 4'b1001);
        leg_clr_we = 1; leg_clr_data = 4'b1000; leg_evt = 4'b1000;
        tick();
        check("R3 set beats clear", leg_sts, 4'b1001);
        clear_all();
        check("R3 clear all", leg_sts, 0);
    endtask

    task automatic t_mode_smi_only();
        mode = 2'b00; acp_en = '1; leg_en = '1;
        acp_evt = 6'b000010;
        tick();
        check("R4 acp no lines", {smi_n, pme_n}, 2'b11);
        check("R8 wake in smi-only", wake_req, 1);
        tick();
        check("R8 one-cycle pulse", wake_req, 0);
        leg_evt = 4'b0001;
        tick();
        check("R4 legacy smi", {smi_n, pme_n}, 2'b01);
        clear_all();
    endtask

    task automatic t_mode_smi_wake();
        mode = 2'b01; acp_en = '1; acp_evt = 6'b100000;
        tick();
        check("R5 smi low pme high", {smi_n, pme_n}, 2'b01);
        check("R5 wake", wake_req, 1);
        acp_evt = 6'b100000;
        tick();
        check("R8 no wake when already set", wake_req, 0);
        clear_all();
    endtask

    task automatic t_mode_sci();
        for (int m = 2; m < 4; m++) begin
            mode = m[1:0]; acp_en = '1; acp_evt = 6'b001000;
            tick();
            check("R6 pme low smi high", {smi_n, pme_n}, 2'b10);
            check("R6 wake", wake_req, 1);
            clear_all();
        end
    endtask

    task automatic t_legacy_nowake();
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0]; leg_en = '1; leg_evt = 4'b1111;
            tick();
            check("R7 legacy no wake", wake_req, 0);
            check("R7 legacy smi", smi_n, 0);
            clear_all();
        end
    endtask

    task automatic t_lockout();
        mode = 2'b10; acp_en = '1;
        pb_override = 1;
        tick();
        acp_evt = 6'b000001;
        tick();
        check("R9 locked no wake", wake_req, 0);
        check("R9 status still set", acp_sts, 6'b000001);
        check("R9 pme still low", pme_n, 0);
        clear_all();
        pb_wake = 1; pb_override = 1;
        tick();
        check("R10 button wake pulse", wake_req, 1);
        tick();
        acp_evt = 6'b000010;
        tick();
        check("R10 lockout released", wake_req, 1);
        clear_all();
    endtask

    task automatic t_hold_level();
        mode = 2'b10; acp_en = '1; acp_evt = 6'b000100;
        tick();
        repeat (5) tick();
        check("R11 held", pme_n, 0);
        acp_en = 6'b111011;
        #1;
        check("R11 enable drop releases", pme_n, 1);
        acp_en = '1;
        #1;
        check("R11 re-enable asserts", pme_n, 0);
        clear_all();
        check("R11 clear releases", pme_n, 1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_enable_gate();
        t_w1c();
        t_mode_smi_only();
        t_mode_smi_wake();
        t_mode_sci();
        t_legacy_nowake();
        t_lockout();
        t_hold_level();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule